// File: doc/BRIEF.md
# Floating-point NaN resolver

This block sits next to a floating-point execution datapath. It decides the result of an operation whenever one of its operands is a NaN. Each cycle it may accept one operation: one or two operand words in single or double precision, an operation class and a sign-operation code, plus a runtime mode bit. The mode bit selects between propagating an operand NaN (quieted) and always returning the canonical default NaN. One cycle later the block reports whether the NaN path overrides the datapath result, and which word to write back. It also keeps a sticky invalid-operation flag that only an explicit clear input resets.

Three classes of operation are handled in different ways. Arithmetic operations quiet, prioritise or replace NaN operands and raise the invalid flag on a signalling NaN. Sign-manipulation operations (copy, absolute value, negate) only rewrite the sign bit of a NaN. Transfers return the NaN bit for bit. Neither of the last two classes ever touches the flag. Single-precision words occupy the low 32 bits of the operand ports.

Top module: `fp_nan_resolver`

## Requirements
- R1: After reset `ovr_valid` is 0, `ovr_result` is 0 and `inv_flag` is 0.
- R2: Outputs are registered: an operation accepted with `in_valid`=1 is reported on the next clock edge. A cycle with `in_valid`=0, or an operation with no NaN operand that the class examines, gives `ovr_valid`=0 and `ovr_result`=0.
- R3: An arithmetic operation (`op_class`=0) with a signalling NaN among its used operands sets `inv_flag` to 1 in both modes. A signalling NaN has an all-ones exponent, a nonzero fraction and a fraction MSB of 0. A quiet NaN has a fraction MSB of 1.
- R4: With `dnan_mode`=1, an arithmetic operation with any NaN operand returns the default NaN, whatever the payloads are: 0x7FC00000 in single precision, 0x7FF8000000000000 in double.
- R5: With `dnan_mode`=0, an arithmetic operation whose only NaN operands are quiet returns a quiet operand NaN unchanged.
- R6: With `dnan_mode`=0, a signalling NaN chosen as the result is returned quieted. Its fraction MSB (bit 22 single, bit 51 double) is set, and its sign and the other payload bits are kept.
- R7: When propagating, a signalling NaN wins over a quiet NaN. Between two NaNs of the same kind, operand A wins over operand B.
- R8: Sign operations (`op_class`=1) act on a NaN in operand A. `sign_op`=0 (copy) leaves it unchanged, 1 (absolute) clears the sign bit, and 2 (negate) inverts it. These operations never set `inv_flag`, in either mode. A non-NaN operand A gives no override.
- R9: Transfers (`op_class`=2, and the unused code 3) return a NaN in operand A bit for bit in both modes, and never set `inv_flag`.
- R10: `inv_flag` stays 1 until a cycle with `clr_inv`=1. If a clear and a new signalling-NaN arithmetic operation fall in the same cycle, the flag ends at 1.
- R11: With `two_ops`=0, operand B is ignored: a NaN in B neither overrides the result nor sets the flag.
- R12: With `is_double`=0, bits 63:32 of both operands are ignored and bits 63:32 of `ovr_result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_a | input | 64 | Operand A (single precision in bits 31:0) |
| op_b | input | 64 | Operand B (single precision in bits 31:0) |
| two_ops | input | 1 | Operand B is used by an arithmetic operation |
| is_double | input | 1 | 1 = double precision, 0 = single |
| op_class | input | 2 | 0 arithmetic, 1 sign operation, 2/3 transfer |
| sign_op | input | 2 | 0 copy, 1 absolute, 2 negate |
| dnan_mode | input | 1 | 1 = always return the default NaN for arithmetic |
| clr_inv | input | 1 | Clears the sticky invalid flag |
| ovr_valid | output | 1 | The result is decided by the NaN path |
| ovr_result | output | 64 | Overriding result word |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench aims at operand ordering. A signalling NaN in operand B paired with a quiet NaN in A must return B quieted. A design that ranks by position alone would return A's payload. It covers both modes with payload-bearing NaNs: a default-NaN design that leaked a fraction bit, or a propagating one that forgot to quiet or dropped the sign, returns a wrong word. It also checks that sign and transfer operations on signalling NaNs leave the flag clear, which catches a flag wired to any signalling NaN. It sends a signalling NaN in an unused B and garbage in the upper half of single-precision words, which exposes decoders that ignore `two_ops` or precision. The sticky flag is tested against a clear and a set that fall in the same cycle.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

   typedef enum logic [1:0] {
      CLS_ARITH = 2'd0,
      CLS_SIGN  = 2'd1,
      CLS_XFER  = 2'd2,
      CLS_XFER2 = 2'd3
   } op_class_e;

   typedef enum logic [1:0] {
      SGN_COPY = 2'd0,
      SGN_ABS  = 2'd1,
      SGN_NEG  = 2'd2,
      SGN_RSVD = 2'd3
   } sign_op_e;

   localparam int unsigned IW = 64;

endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify #(
   parameter int unsigned EXP_S      = 8,
   parameter int unsigned FRAC_S     = 23,
   parameter int unsigned EXP_D      = 11,
   parameter int unsigned FRAC_D     = 52,
   parameter bit          HAS_DOUBLE = 1'b1
) (
   input  logic [fpnan_pkg::IW-1:0] word,
   input  logic                     dbl,
   output logic                     is_nan,
   output logic                     is_snan
);
   localparam int unsigned TOP_S = EXP_S + FRAC_S - 1;

   logic s_nan, s_quiet;
   logic d_nan, d_quiet;

   assign s_nan   = (&word[TOP_S:FRAC_S]) && (|word[FRAC_S-1:0]);
   assign s_quiet = word[FRAC_S-1];

   generate
      if (HAS_DOUBLE) begin : g_dbl
         localparam int unsigned TOP_D = EXP_D + FRAC_D - 1;
         assign d_nan   = (&word[TOP_D:FRAC_D]) && (|word[FRAC_D-1:0]);
         assign d_quiet = word[FRAC_D-1];
      end else begin : g_sgl
         assign d_nan   = 1'b0;
         assign d_quiet = 1'b0;
      end
   endgenerate

   always_comb begin
      if (dbl) begin
         is_nan  = d_nan;
         is_snan = d_nan && !d_quiet;
      end else begin
         is_nan  = s_nan;
         is_snan = s_nan && !s_quiet;
      end
   end
endmodule

// File: rtl/fpnan_pick.sv
module fpnan_pick (
   input  logic [fpnan_pkg::IW-1:0] a_word,
   input  logic [fpnan_pkg::IW-1:0] b_word,
   input  logic                     a_nan,
   input  logic                     a_snan,
   input  logic                     b_nan,
   input  logic                     b_snan,
   output logic [fpnan_pkg::IW-1:0] pick
);
   always_comb begin
      if (a_snan)      pick = a_word;
      else if (b_snan) pick = b_word;
      else if (a_nan)  pick = a_word;
      else if (b_nan)  pick = b_word;
      else             pick = '0;
   end
endmodule

// File: rtl/fpnan_signop.sv
module fpnan_signop #(
   parameter int unsigned EXP_S      = 8,
   parameter int unsigned FRAC_S     = 23,
   parameter int unsigned EXP_D      = 11,
   parameter int unsigned FRAC_D     = 52,
   parameter bit          HAS_DOUBLE = 1'b1
) (
   input  logic [fpnan_pkg::IW-1:0] word,
   input  logic                     dbl,
   input  logic [1:0]               op,
   output logic [fpnan_pkg::IW-1:0] result
);
   import fpnan_pkg::*;
   localparam int unsigned SB_S = EXP_S + FRAC_S;

   logic       cur_sign;
   logic       new_sign;
   sign_op_e   sop;

   assign sop = sign_op_e'(op);

   generate
      if (HAS_DOUBLE) begin : g_dbl
         localparam int unsigned SB_D = EXP_D + FRAC_D;
         assign cur_sign = dbl ? word[SB_D] : word[SB_S];
         always_comb begin
            result = word;
            if (dbl) result[SB_D] = new_sign;
            else     result[SB_S] = new_sign;
         end
      end else begin : g_sgl
         assign cur_sign = word[SB_S];
         always_comb begin
            result       = word;
            result[SB_S] = new_sign;
         end
      end
   endgenerate

   always_comb begin
      unique case (sop)
         SGN_ABS: new_sign = 1'b0;
         SGN_NEG: new_sign = !cur_sign;
         default: new_sign = cur_sign;
      endcase
   end
endmodule

// File: rtl/fp_nan_resolver.sv
module fp_nan_resolver #(
   parameter int unsigned EXP_S      = 8,
   parameter int unsigned FRAC_S     = 23,
   parameter int unsigned EXP_D      = 11,
   parameter int unsigned FRAC_D     = 52,
   parameter bit          HAS_DOUBLE = 1'b1,
   localparam int unsigned W_S       = 1 + EXP_S + FRAC_S,
   localparam int unsigned W_D       = 1 + EXP_D + FRAC_D,
   localparam int unsigned DW        = HAS_DOUBLE ? W_D : W_S
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic          two_ops,
   input  logic          is_double,
   input  logic [1:0]    op_class,
   input  logic [1:0]    sign_op,
   input  logic          dnan_mode,
   input  logic          clr_inv,
   output logic          ovr_valid,
   output logic [DW-1:0] ovr_result,
   output logic          inv_flag
);
   import fpnan_pkg::*;

   generate
      if (W_S != 32) begin : g_bad_s
         $error("single format must be 32 bits wide");
      end
      if (HAS_DOUBLE && (W_D != 64)) begin : g_bad_d
         $error("double format must be 64 bits wide");
      end
   endgenerate

   localparam logic [IW-1:0] DEF_S = IW'({1'b0, {EXP_S{1'b1}}, 1'b1, {(FRAC_S-1){1'b0}}});
   localparam logic [IW-1:0] DEF_D = {1'b0, {EXP_D{1'b1}}, 1'b1, {(FRAC_D-1){1'b0}}};

   op_class_e  cls;
   logic       dbl_eff;
   logic [IW-1:0] opw [2];
   logic [1:0] nan_v, snan_v;
   logic       b_use;
   logic       a_nan, a_snan, b_nan, b_snan;
   logic       nan_any, snan_any;
   logic [IW-1:0] picked, quieted, signed_w, res_d;
   logic       ovr_d, set_inv;

   assign cls     = op_class_e'(op_class);
   assign dbl_eff = HAS_DOUBLE && is_double;

   always_comb begin
      opw[0] = IW'(op_a);
      opw[1] = IW'(op_b);
      if (!dbl_eff) begin
         opw[0][IW-1:32] = '0;
         opw[1][IW-1:32] = '0;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < 2; gi++) begin : g_cls
         fpnan_classify #(
            .EXP_S(EXP_S), .FRAC_S(FRAC_S), .EXP_D(EXP_D),
            .FRAC_D(FRAC_D), .HAS_DOUBLE(HAS_DOUBLE)
         ) u_cls (
            .word(opw[gi]), .dbl(dbl_eff),
            .is_nan(nan_v[gi]), .is_snan(snan_v[gi])
         );
      end
   endgenerate

   assign b_use  = two_ops && (cls == CLS_ARITH);
   assign a_nan  = nan_v[0];
   assign a_snan = snan_v[0];
   assign b_nan  = nan_v[1] && b_use;
   assign b_snan = snan_v[1] && b_use;
   assign nan_any  = a_nan || b_nan;
   assign snan_any = a_snan || b_snan;

   fpnan_pick u_pick (
      .a_word(opw[0]), .b_word(opw[1]),
      .a_nan(a_nan), .a_snan(a_snan), .b_nan(b_nan), .b_snan(b_snan),
      .pick(picked)
   );

   always_comb begin
      quieted = picked;
      if (dbl_eff) quieted[FRAC_D-1] = 1'b1;
      else         quieted[FRAC_S-1] = 1'b1;
   end

   fpnan_signop #(
      .EXP_S(EXP_S), .FRAC_S(FRAC_S), .EXP_D(EXP_D),
      .FRAC_D(FRAC_D), .HAS_DOUBLE(HAS_DOUBLE)
   ) u_sign (
      .word(opw[0]), .dbl(dbl_eff), .op(sign_op), .result(signed_w)
   );

   always_comb begin
      unique case (cls)
         CLS_ARITH: begin
            ovr_d = nan_any;
            if (dnan_mode) res_d = dbl_eff ? DEF_D : DEF_S;
            else           res_d = quieted;
         end
         CLS_SIGN: begin
            ovr_d = a_nan;
            res_d = signed_w;
         end
         default: begin
            ovr_d = a_nan;
            res_d = opw[0];
         end
      endcase
   end

   assign set_inv = in_valid && (cls == CLS_ARITH) && snan_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_valid  <= 1'b0;
         ovr_result <= '0;
         inv_flag   <= 1'b0;
      end else begin
         ovr_valid  <= in_valid && ovr_d;
         ovr_result <= (in_valid && ovr_d) ? res_d[DW-1:0] : '0;
         inv_flag   <= (inv_flag && !clr_inv) || set_inv;
      end
   end

   // ---------------- assertions ----------------
   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!ovr_valid && ovr_result == '0));

   assert_snan_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_ARITH && snan_any) |=> inv_flag);

   assert_dnan_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid && $past(in_valid) && $past(dnan_mode) && $past(cls) == CLS_ARITH)
      |-> (IW'(ovr_result) == ($past(dbl_eff) ? DEF_D : DEF_S)));

   assert_arith_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid && $past(cls) == CLS_ARITH && !$past(dbl_eff))
      |-> ovr_result[FRAC_S-1]);

   assert_sign_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls != CLS_ARITH && !inv_flag) |=> !inv_flag);

   assert_xfer_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (cls == CLS_XFER || cls == CLS_XFER2) && dbl_eff)
      |=> (!ovr_valid || ovr_result == $past(op_a)));

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_flag && !clr_inv) |=> inv_flag);

   assert_single_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dbl_eff) |=> (IW'(ovr_result) >> 32) == '0);
endmodule

// File: tb/fp_nan_resolver_tb_top.sv
`timescale 1ns/1ps
module fp_nan_resolver_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic        two_ops = 1'b0, is_double = 1'b0;
   logic [1:0]  op_class = 2'd0, sign_op = 2'd0;
   logic        dnan_mode = 1'b0, clr_inv = 1'b0;
   logic        ovr_valid;
   logic [63:0] ovr_result;
   logic        inv_flag;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [65:0] exp_q [$];
   string       req_q [$];

   always #4 clk = ~clk;

   fp_nan_resolver dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .two_ops(two_ops), .is_double(is_double), .op_class(op_class),
      .sign_op(sign_op), .dnan_mode(dnan_mode), .clr_inv(clr_inv),
      .ovr_valid(ovr_valid), .ovr_result(ovr_result), .inv_flag(inv_flag)
   );

   localparam logic [63:0] NUM  = 64'h0000_0000_3F80_0000;
   localparam logic [63:0] QSA  = 64'h0000_0000_7FC0_0001;
   localparam logic [63:0] QSB  = 64'h0000_0000_7FC0_0002;
   localparam logic [63:0] SSB  = 64'h0000_0000_7F80_0005;
   localparam logic [63:0] SSN  = 64'h0000_0000_FF80_0003;
   localparam logic [63:0] NUMD = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] QD   = 64'h7FF8_0000_0000_0011;
   localparam logic [63:0] SD   = 64'h7FF0_0000_0000_0022;

   task automatic check(input string req, input logic [65:0] act, input logic [65:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual valid=%b result=%h inv=%b expected valid=%b result=%h inv=%b",
                  req, act[65], act[64:1], act[0], expv[65], expv[64:1], expv[0]);
      end
   endtask

   task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic two,
                        input logic dbl, input logic [1:0] cls, input logic [1:0] sop,
                        input logic dn, input logic clr,
                        input logic ev, input logic [63:0] er, input logic ei,
                        input string req);
      @(negedge clk);
      in_valid = 1'b1; op_a = a; op_b = b; two_ops = two; is_double = dbl;
      op_class = cls; sign_op = sop; dnan_mode = dn; clr_inv = clr;
      exp_q.push_back({ev, er, ei});
      req_q.push_back(req);
   endtask

   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic [65:0] e;
         string r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         check(r, {ovr_valid, ovr_result, inv_flag}, e);
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", {ovr_valid, ovr_result, inv_flag}, 66'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {ovr_valid, ovr_result, inv_flag}, 66'd0);

      // drive(a, b, two, dbl, cls, sop, dnan, clr, exp_valid, exp_result, exp_inv, req)
      drive(NUM, NUM, 1, 0, 0, 0, 0, 0, 0, 64'h0, 0, "R2");
      drive(QSA, NUM, 1, 0, 0, 0, 0, 0, 1, QSA, 0, "R5");
      drive(NUM, QSB, 1, 0, 0, 0, 0, 0, 1, QSB, 0, "R5");
      drive(QSA, QSB, 1, 0, 0, 0, 0, 0, 1, QSA, 0, "R7");
      drive(QSA, SSB, 1, 0, 0, 0, 0, 0, 1, 64'h7FC0_0005, 1, "R7");
      drive(NUM, NUM, 1, 0, 0, 0, 0, 0, 0, 64'h0, 1, "R10");
      drive(NUM, NUM, 1, 0, 0, 0, 0, 1, 0, 64'h0, 0, "R10");
      drive(SSN, NUM, 0, 0, 0, 0, 0, 0, 1, 64'hFFC0_0003, 1, "R6");
      drive(SSB, NUM, 1, 0, 0, 0, 0, 1, 1, 64'h7FC0_0005, 1, "R10");
      drive(NUM, NUM, 1, 0, 0, 0, 0, 1, 0, 64'h0, 0, "R10");
      drive(NUM, SSB, 0, 0, 0, 0, 0, 0, 0, 64'h0, 0, "R11");
      drive(QSA, NUM, 1, 0, 0, 0, 1, 0, 1, 64'h7FC0_0000, 0, "R4");
      drive(SSB, SSN, 1, 0, 0, 0, 1, 0, 1, 64'h7FC0_0000, 1, "R3");
      drive(NUM, NUM, 1, 0, 0, 0, 1, 1, 0, 64'h0, 0, "R10");
      drive(QD, NUMD, 1, 1, 0, 0, 1, 0, 1, 64'h7FF8_0000_0000_0000, 0, "R4");
      drive(QD, SD, 1, 1, 0, 0, 0, 0, 1, 64'h7FF8_0000_0000_0022, 1, "R6");
      drive(NUM, NUM, 1, 0, 0, 0, 0, 1, 0, 64'h0, 0, "R10");
      drive(SSB, NUM, 0, 0, 1, 0, 0, 0, 1, SSB, 0, "R8");
      drive(SSN, NUM, 0, 0, 1, 1, 0, 0, 1, 64'h7F80_0003, 0, "R8");
      drive(QSA, NUM, 0, 0, 1, 2, 1, 0, 1, 64'hFFC0_0001, 0, "R8");
      drive(SD, NUMD, 0, 1, 1, 2, 0, 0, 1, 64'hFFF0_0000_0000_0022, 0, "R8");
      drive(NUM, NUM, 0, 0, 1, 2, 0, 0, 0, 64'h0, 0, "R8");
      drive(SSB, NUM, 0, 0, 2, 0, 1, 0, 1, SSB, 0, "R9");
      drive(SD, NUMD, 0, 1, 2, 0, 0, 0, 1, SD, 0, "R9");
      drive(SSN, NUM, 0, 0, 3, 0, 0, 0, 1, SSN, 0, "R9");
      drive(64'hDEAD_BEEF_7FC0_0001, NUM, 1, 0, 0, 0, 0, 0, 1, QSA, 0, "R12");
      drive(64'h7FF8_0000_3F80_0000, 64'h7FF0_0001_3F80_0000, 1, 0, 0, 0, 0, 0, 0, 64'h0, 0, "R12");

      @(negedge clk);
      in_valid = 1'b0; clr_inv = 1'b0;
      @(negedge clk);
      check("R2", {ovr_valid, ovr_result, inv_flag}, 66'd0);
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule